// File: doc/BRIEF.md
# Single-Assignment Structure Memory Bank

This block is one bank of a dataflow machine's structure memory. A tracked lower tier gives every cell a presence state, so a producer writes a cell once and consumers may ask for it before or after that write. A read that arrives early is parked inside the bank together with its return route. The write that later fills the cell sends the value to that route. Only one parked read can exist per bank. The tracked tier also serves clears, a reserve marker and three atomic read-modify-write operations. Addresses at or above the tier boundary form a raw tier with no presence bookkeeping.

Requests arrive one at a time over a valid/ready input. The bank deasserts ready while it processes a request or delivers a result. Results leave on a response channel as a one-cycle pulse that carries the data and the return route. A request that breaks a rule produces a one-cycle error pulse and no response.

Top module: `smem_bank`

## Requirements
- R1: After reset `req_ready` is high and `resp_valid` and `err` are low. A request accepted on clock edge k keeps `req_ready` low until edge k+1. When it produces a response, `resp_valid` is high only between edges k+1 and k+2 and `req_ready` returns after k+2; otherwise `req_ready` returns after k+1.
- R2: Opcode codes are read 0, write 1, clear 2, reserve 3, increment 4, decrement 5, compare-and-swap 6. A read (0) of a FULL tracked cell responds with the stored data on the request's own route.
- R3: A read of a tracked cell that is not FULL gives no response and parks. A later write to that cell stores the data, makes the cell FULL and responds with the written value on the parked read's route.
- R4: While one read is parked, another read of a non-FULL tracked cell raises `err` and is dropped. The parked read is unaffected.
- R5: A clear empties a tracked cell. If the cell held a parked read, that read is cancelled, so the next write to the cell gives no response and the park slot is free again.
- R6: Increment and decrement on a FULL cell below the atomic limit respond with the old value and store it plus or minus one, wrapping at 16 bits.
- R7: Compare-and-swap on a FULL cell below the atomic limit responds with the old value and stores the data field only when the old value equals the flags field.
- R8: An atomic on a non-FULL cell or at an address at or above the atomic limit (256) raises `err`, gives no response and leaves the cell unchanged.
- R9: At or above the tier boundary (256), a read responds at once with the stored value (zero after reset) and a write always stores, with no presence check.
- R10: Clear, reserve and atomics aimed at the raw tier raise `err` and are dropped without changing the cell.
- R11: A write to a FULL tracked cell raises `err` and leaves the stored value unchanged.
- R12: Reserve moves an EMPTY tracked cell to RESERVED and has no effect on a FULL cell. A RESERVED cell counts as not FULL for reads and accepts one write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Bank can accept a request |
| req_addr | input | ADDR_W | Cell address |
| req_op | input | 3 | Opcode |
| req_flags | input | DATA_W | Expected value for compare-and-swap |
| req_data | input | DATA_W | Write or swap data |
| req_route | input | ROUTE_W | Return route for the result |
| resp_valid | output | 1 | One-cycle result pulse |
| resp_route | output | ROUTE_W | Route of the result |
| resp_data | output | DATA_W | Result value |
| err | output | 1 | One-cycle pulse for a rejected request |

## Verification
On every cycle the assertions check the handshake discipline. The bank goes busy after it accepts a request, a result or error never appears in the cycle right after acceptance, results and errors are single-cycle pulses that never coincide, and ready stays low during delivery. Only the directed scenarios can show the rules that depend on memory contents. These are parking and later completion of reads, cancellation by clear, the single park slot, single assignment, atomic arithmetic and the swap comparison, and the separate rules of the raw tier.

// File: rtl/smem_pkg.sv
package smem_pkg;
    typedef enum logic [2:0] {
        OP_READ    = 3'd0,
        OP_WRITE   = 3'd1,
        OP_CLEAR   = 3'd2,
        OP_RESERVE = 3'd3,
        OP_INC     = 3'd4,
        OP_DEC     = 3'd5,
        OP_CAS     = 3'd6,
        OP_BAD     = 3'd7
    } op_e;

    typedef enum logic [1:0] {
        PR_EMPTY    = 2'd0,
        PR_RESERVED = 2'd1,
        PR_FULL     = 2'd2,
        PR_WAITING  = 2'd3
    } pres_e;

    typedef enum logic [1:0] {
        FSM_IDLE = 2'd0,
        FSM_PROC = 2'd1,
        FSM_SEND = 2'd2
    } fsm_e;
endpackage

// File: rtl/smem_regfile.sv
module smem_regfile #(
    parameter int DEPTH = 256,
    parameter int WIDTH = 16,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);
    logic [WIDTH-1:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/smem_action.sv
module smem_action
    import smem_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 16,
    parameter int TIER       = 256,
    parameter int ATOM_LIMIT = 256
) (
    input  op_e               op,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] flags,
    input  logic [DATA_W-1:0] data,
    input  logic [DATA_W-1:0] cur_data,
    input  pres_e             cur_pres,
    input  logic              pend_valid,
    output logic              act_err,
    output logic              act_respond,
    output logic [DATA_W-1:0] act_resp_data,
    output logic              act_from_pend,
    output logic              act_mem_we,
    output logic [DATA_W-1:0] act_mem_wdata,
    output logic              act_pres_we,
    output pres_e             act_pres_wval,
    output logic              act_park,
    output logic              act_unpark
);
    localparam logic [ADDR_W:0] TIER_EXT = (ADDR_W+1)'(TIER);
    localparam logic [ADDR_W:0] ATOM_EXT = (ADDR_W+1)'(ATOM_LIMIT);

    logic is_raw;
    logic atom_ok;

    always_comb begin
        is_raw  = {1'b0, addr} >= TIER_EXT;
        atom_ok = !is_raw && ({1'b0, addr} < ATOM_EXT) && (cur_pres == PR_FULL);

        act_err       = 1'b0;
        act_respond   = 1'b0;
        act_resp_data = cur_data;
        act_from_pend = 1'b0;
        act_mem_we    = 1'b0;
        act_mem_wdata = data;
        act_pres_we   = 1'b0;
        act_pres_wval = cur_pres;
        act_park      = 1'b0;
        act_unpark    = 1'b0;

        unique case (op)
            OP_READ: begin
                if (is_raw || cur_pres == PR_FULL) begin
                    act_respond = 1'b1;
                end else if (pend_valid) begin
                    act_err = 1'b1;
                end else begin
                    act_pres_we   = 1'b1;
                    act_pres_wval = PR_WAITING;
                    act_park      = 1'b1;
                end
            end
            OP_WRITE: begin
                if (is_raw) begin
                    act_mem_we = 1'b1;
                end else if (cur_pres == PR_FULL) begin
                    act_err = 1'b1;
                end else begin
                    act_mem_we    = 1'b1;
                    act_pres_we   = 1'b1;
                    act_pres_wval = PR_FULL;
                    if (cur_pres == PR_WAITING) begin
                        act_respond   = 1'b1;
                        act_resp_data = data;
                        act_from_pend = 1'b1;
                        act_unpark    = 1'b1;
                    end
                end
            end
            OP_CLEAR: begin
                if (is_raw) begin
                    act_err = 1'b1;
                end else begin
                    act_mem_we    = 1'b1;
                    act_mem_wdata = '0;
                    act_pres_we   = 1'b1;
                    act_pres_wval = PR_EMPTY;
                    act_unpark    = (cur_pres == PR_WAITING);
                end
            end
            OP_RESERVE: begin
                if (is_raw) begin
                    act_err = 1'b1;
                end else if (cur_pres == PR_EMPTY) begin
                    act_pres_we   = 1'b1;
                    act_pres_wval = PR_RESERVED;
                end
            end
            OP_INC, OP_DEC, OP_CAS: begin
                if (!atom_ok) begin
                    act_err = 1'b1;
                end else begin
                    act_respond = 1'b1;
                    if (op == OP_INC) begin
                        act_mem_we    = 1'b1;
                        act_mem_wdata = cur_data + DATA_W'(1);
                    end else if (op == OP_DEC) begin
                        act_mem_we    = 1'b1;
                        act_mem_wdata = cur_data - DATA_W'(1);
                    end else begin
                        act_mem_we    = (cur_data == flags);
                        act_mem_wdata = data;
                    end
                end
            end
            default: act_err = 1'b1;
        endcase
    end
endmodule

// File: rtl/smem_bank.sv
module smem_bank
    import smem_pkg::*;
#(
    parameter int ADDR_W     = 9,
    parameter int DATA_W     = 16,
    parameter int ROUTE_W    = 8,
    parameter int TIER       = 256,
    parameter int ATOM_LIMIT = 256
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [2:0]         req_op,
    input  logic [DATA_W-1:0]  req_flags,
    input  logic [DATA_W-1:0]  req_data,
    input  logic [ROUTE_W-1:0] req_route,
    output logic               resp_valid,
    output logic [ROUTE_W-1:0] resp_route,
    output logic [DATA_W-1:0]  resp_data,
    output logic               err
);
    localparam int CELLS  = 1 << ADDR_W;
    localparam int TRK_AW = $clog2(TIER);

    typedef struct packed {
        fsm_e               fsm;
        op_e                op;
        logic [ADDR_W-1:0]  addr;
        logic [DATA_W-1:0]  flags;
        logic [DATA_W-1:0]  data;
        logic [ROUTE_W-1:0] route;
        logic               resp_valid;
        logic [DATA_W-1:0]  resp_data;
        logic [ROUTE_W-1:0] resp_route;
        logic               err;
        logic               pend_valid;
        logic [ROUTE_W-1:0] pend_route;
    } state_t;

    state_t st_d, st_q;

    logic [DATA_W-1:0] cell_rd;
    logic [1:0]        pres_rd;
    logic              mem_we_d;
    logic              pres_we_d;

    logic              a_err, a_respond, a_from_pend, a_mem_we, a_pres_we, a_park, a_unpark;
    logic [DATA_W-1:0] a_resp_data, a_mem_wdata;
    pres_e             a_pres_wval;

    smem_regfile #(.DEPTH(CELLS), .WIDTH(DATA_W)) u_cells (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (mem_we_d),
        .waddr (st_q.addr),
        .wdata (a_mem_wdata),
        .raddr (st_q.addr),
        .rdata (cell_rd)
    );

    smem_regfile #(.DEPTH(TIER), .WIDTH(2)) u_pres (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (pres_we_d),
        .waddr (st_q.addr[TRK_AW-1:0]),
        .wdata (a_pres_wval),
        .raddr (st_q.addr[TRK_AW-1:0]),
        .rdata (pres_rd)
    );

    smem_action #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .TIER(TIER), .ATOM_LIMIT(ATOM_LIMIT)
    ) u_action (
        .op            (st_q.op),
        .addr          (st_q.addr),
        .flags         (st_q.flags),
        .data          (st_q.data),
        .cur_data      (cell_rd),
        .cur_pres      (pres_e'(pres_rd)),
        .pend_valid    (st_q.pend_valid),
        .act_err       (a_err),
        .act_respond   (a_respond),
        .act_resp_data (a_resp_data),
        .act_from_pend (a_from_pend),
        .act_mem_we    (a_mem_we),
        .act_mem_wdata (a_mem_wdata),
        .act_pres_we   (a_pres_we),
        .act_pres_wval (a_pres_wval),
        .act_park      (a_park),
        .act_unpark    (a_unpark)
    );

    always_comb begin
        st_d            = st_q;
        st_d.resp_valid = 1'b0;
        st_d.err        = 1'b0;
        mem_we_d        = 1'b0;
        pres_we_d       = 1'b0;

        unique case (st_q.fsm)
            FSM_IDLE: begin
                if (req_valid) begin
                    st_d.fsm   = FSM_PROC;
                    st_d.op    = op_e'(req_op);
                    st_d.addr  = req_addr;
                    st_d.flags = req_flags;
                    st_d.data  = req_data;
                    st_d.route = req_route;
                end
            end
            FSM_PROC: begin
                mem_we_d  = a_mem_we;
                pres_we_d = a_pres_we;
                st_d.err  = a_err;
                if (a_park) begin
                    st_d.pend_valid = 1'b1;
                    st_d.pend_route = st_q.route;
                end
                if (a_unpark) st_d.pend_valid = 1'b0;
                if (a_respond) begin
                    st_d.fsm        = FSM_SEND;
                    st_d.resp_valid = 1'b1;
                    st_d.resp_data  = a_resp_data;
                    st_d.resp_route = a_from_pend ? st_q.pend_route : st_q.route;
                end else begin
                    st_d.fsm = FSM_IDLE;
                end
            end
            default: st_d.fsm = FSM_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.fsm <= FSM_IDLE;
            st_q.op  <= OP_READ;
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready  = (st_q.fsm == FSM_IDLE);
    assign resp_valid = st_q.resp_valid;
    assign resp_data  = st_q.resp_data;
    assign resp_route = st_q.resp_route;
    assign err        = st_q.err;
endmodule

// File: rtl/smem_bank_chk.sv
module smem_bank_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic resp_valid,
    input logic err
);
    assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_no_early_result_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (!resp_valid && !err));

    assert_resp_pulse_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

    assert_not_ready_in_delivery_R1: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    assert_err_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !resp_valid);

    assert_err_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);
endmodule

bind smem_bank smem_bank_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .resp_valid (resp_valid),
    .err        (err)
);

// File: tb/sim_smem_bank.sv
module sim_smem_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [8:0]  req_addr = '0;
    logic [2:0]  req_op = '0;
    logic [15:0] req_flags = '0;
    logic [15:0] req_data = '0;
    logic [7:0]  req_route = '0;
    logic        resp_valid;
    logic [7:0]  resp_route;
    logic [15:0] resp_data;
    logic        err;

    int checks = 0;
    int errors = 0;

    logic        r_resp, r_err, r_ready_mid, r_ready_end;
    logic [15:0] r_data;
    logic [7:0]  r_route;

    localparam logic [2:0] RD = 3'd0, WR = 3'd1, CLR = 3'd2, RSV = 3'd3,
                           INC = 3'd4, DEC = 3'd5, CAS = 3'd6;

    always #5 clk = ~clk;

    smem_bank u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_op(req_op), .req_flags(req_flags),
        .req_data(req_data), .req_route(req_route), .resp_valid(resp_valid),
        .resp_route(resp_route), .resp_data(resp_data), .err(err)
    );

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] op, input logic [8:0] addr,
                         input logic [15:0] flags, input logic [15:0] data,
                         input logic [7:0] route);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr;
        req_flags = flags; req_data = data; req_route = route;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        r_ready_mid = req_ready;
        @(posedge clk);
        @(negedge clk);
        r_resp = resp_valid; r_err = err; r_data = resp_data; r_route = resp_route;
        if (resp_valid) begin
            chk("R1 ready low during delivery", req_ready, 0);
            @(posedge clk);
            @(negedge clk);
            chk("R1 single-cycle response", resp_valid, 0);
        end
        r_ready_end = req_ready;
        chk("R1 busy while processing", r_ready_mid, 0);
        chk("R1 ready after completion", r_ready_end, 1);
    endtask

    task automatic want_resp(string tag, int data, int route);
        chk({tag, " response"}, r_resp, 1);
        chk({tag, " err"}, r_err, 0);
        chk({tag, " data"}, r_data, data);
        chk({tag, " route"}, r_route, route);
    endtask

    task automatic want_none(string tag);
        chk({tag, " no response"}, r_resp, 0);
        chk({tag, " no err"}, r_err, 0);
    endtask

    task automatic want_err(string tag);
        chk({tag, " err"}, r_err, 1);
        chk({tag, " no response"}, r_resp, 0);
    endtask

    task automatic t_reset;
        chk("R1 reset ready", req_ready, 1);
        chk("R1 reset resp_valid", resp_valid, 0);
        chk("R1 reset err", err, 0);
        issue(RD, 9'd300, 0, 0, 8'h01);
        want_resp("R9 raw read after reset", 0, 8'h01);
    endtask

    task automatic t_write_read;
        issue(WR, 9'd5, 0, 16'h1234, 8'h10);
        want_none("R2 write empty");
        issue(RD, 9'd5, 0, 0, 8'h21);
        want_resp("R2 read full", 16'h1234, 8'h21);
    endtask

    task automatic t_single_assign;
        issue(WR, 9'd5, 0, 16'h9999, 8'h10);
        want_err("R11 rewrite full");
        issue(RD, 9'd5, 0, 0, 8'h22);
        want_resp("R11 value kept", 16'h1234, 8'h22);
    endtask

    task automatic t_deferred;
        issue(RD, 9'd10, 0, 0, 8'h33);
        want_none("R3 park");
        issue(WR, 9'd10, 0, 16'hBEEF, 8'h44);
        want_resp("R3 completion", 16'hBEEF, 8'h33);
        issue(RD, 9'd10, 0, 0, 8'h55);
        want_resp("R3 now full", 16'hBEEF, 8'h55);
    endtask

    task automatic t_one_pending;
        issue(RD, 9'd20, 0, 0, 8'h01);
        want_none("R4 first park");
        issue(RD, 9'd21, 0, 0, 8'h02);
        want_err("R4 second park");
        issue(WR, 9'd21, 0, 16'h2121, 8'h03);
        want_none("R4 dropped read not kept");
        issue(WR, 9'd20, 0, 16'h2020, 8'h04);
        want_resp("R4 first still completes", 16'h2020, 8'h01);
    endtask

    task automatic t_clear;
        issue(RD, 9'd30, 0, 0, 8'h07);
        want_none("R5 park");
        issue(CLR, 9'd30, 0, 0, 8'h00);
        want_none("R5 clear");
        issue(WR, 9'd30, 0, 16'h3030, 8'h09);
        want_none("R5 cancelled");
        issue(RD, 9'd30, 0, 0, 8'h0A);
        want_resp("R5 written", 16'h3030, 8'h0A);
        issue(RD, 9'd31, 0, 0, 8'h08);
        want_none("R5 slot free");
        issue(WR, 9'd31, 0, 16'h3131, 8'h00);
        want_resp("R5 new park completes", 16'h3131, 8'h08);
        issue(CLR, 9'd31, 0, 0, 8'h00);
        want_none("R5 clear full");
        issue(WR, 9'd31, 0, 16'h0031, 8'h00);
        want_none("R5 cleared cell writable");
    endtask

    task automatic t_reserve;
        issue(RSV, 9'd40, 0, 0, 8'h00);
        want_none("R12 reserve");
        issue(RD, 9'd40, 0, 0, 8'h41);
        want_none("R12 reserved parks");
        issue(WR, 9'd40, 0, 16'h4040, 8'h00);
        want_resp("R12 reserved completes", 16'h4040, 8'h41);
        issue(RSV, 9'd5, 0, 0, 8'h00);
        want_none("R12 reserve on full");
        issue(RD, 9'd5, 0, 0, 8'h42);
        want_resp("R12 full unaffected", 16'h1234, 8'h42);
    endtask

    task automatic t_atomics;
        issue(WR, 9'd50, 0, 16'hFFFF, 8'h00);
        issue(INC, 9'd50, 0, 0, 8'h51);
        want_resp("R6 inc old", 16'hFFFF, 8'h51);
        issue(RD, 9'd50, 0, 0, 8'h52);
        want_resp("R6 inc wrap", 16'h0000, 8'h52);
        issue(DEC, 9'd50, 0, 0, 8'h53);
        want_resp("R6 dec old", 16'h0000, 8'h53);
        issue(RD, 9'd50, 0, 0, 8'h54);
        want_resp("R6 dec wrap", 16'hFFFF, 8'h54);
    endtask

    task automatic t_cas;
        issue(WR, 9'd60, 0, 16'h0100, 8'h00);
        issue(CAS, 9'd60, 16'h0200, 16'h0300, 8'h61);
        want_resp("R7 miss old", 16'h0100, 8'h61);
        issue(RD, 9'd60, 0, 0, 8'h62);
        want_resp("R7 miss kept", 16'h0100, 8'h62);
        issue(CAS, 9'd60, 16'h0100, 16'h0300, 8'h63);
        want_resp("R7 hit old", 16'h0100, 8'h63);
        issue(RD, 9'd60, 0, 0, 8'h64);
        want_resp("R7 hit swapped", 16'h0300, 8'h64);
    endtask

    task automatic t_atomic_err;
        issue(INC, 9'd70, 0, 0, 8'h71);
        want_err("R8 atomic on empty");
        issue(WR, 9'd70, 0, 16'h7070, 8'h00);
        want_none("R8 cell still empty");
        issue(WR, 9'd300, 0, 16'h0AB0, 8'h00);
        issue(DEC, 9'd300, 0, 0, 8'h72);
        want_err("R8 atomic above limit");
        issue(RD, 9'd300, 0, 0, 8'h73);
        want_resp("R8 raw unchanged", 16'h0AB0, 8'h73);
    endtask

    task automatic t_raw;
        issue(RD, 9'd400, 0, 0, 8'h81);
        want_resp("R9 raw unwritten", 0, 8'h81);
        issue(WR, 9'd400, 0, 16'h5555, 8'h00);
        want_none("R9 raw write");
        issue(WR, 9'd400, 0, 16'hAAAA, 8'h00);
        want_none("R9 raw rewrite");
        issue(RD, 9'd400, 0, 0, 8'h82);
        want_resp("R9 raw last value", 16'hAAAA, 8'h82);
    endtask

    task automatic t_raw_tracked_ops;
        issue(CLR, 9'd400, 0, 0, 8'h00);
        want_err("R10 clear on raw");
        issue(RSV, 9'd400, 0, 0, 8'h00);
        want_err("R10 reserve on raw");
        issue(CAS, 9'd400, 16'hAAAA, 16'h1111, 8'h00);
        want_err("R10 swap on raw");
        issue(RD, 9'd400, 0, 0, 8'h91);
        want_resp("R10 raw unchanged", 16'hAAAA, 8'h91);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL R1 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_write_read;
        t_single_assign;
        t_deferred;
        t_one_pending;
        t_clear;
        t_reserve;
        t_atomics;
        t_cas;
        t_atomic_err;
        t_raw;
        t_raw_tracked_ops;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule